// File: doc/BRIEF.md
# Four-channel prescaled PWM controller

This block generates four pulse-width modulated outputs from a single clock. Each channel owns a 16-bit prescaler. The prescaler emits one tick every N input clocks, where N is the value programmed for it. An 8-bit duty counter steps once per tick, so a full PWM period is 256 ticks, or N × 256 clocks. At the start of each period the output is high while the duty counter is below the programmed duty value D, which gives N × D high clocks.

Software controls the block through a small word-addressed register port. The port has a write strobe, a read strobe, an 8-bit byte address and 32-bit data. Per channel, software can set:
- an output enable;
- a force-high override;
- a counting enable that gates both the prescaler and the duty counter;
- a selector that lets the duty counter follow any of the four prescalers.

Programming changes apply on the next clock edge and do not wait for the running period to end.

Top module: `pwm4_ctrl`

Register map (word offsets in bytes; a write or read with addr[1:0] not zero is ignored or reads 0):

| Offset | Name | Contents |
|---|---|---|
| 0x00 | mode | bit c = output enable of channel c; bit 8+c = force-high of channel c |
| 0x04 | count enable | bit c = counting enable of channel c |
| 0x08 + 4c | prescaler c | bits 15:0 = divider value N |
| 0x18 + 4c | duty c | bits 7:0 = duty D; bits 9:8 = index of the prescaler that steps this channel |

## Requirements
- R1: While reset is active, and after it, every register reads 0, every output is low and rdata is 0 until the first read.
- R2: Each register reads back its last written value, with the undefined bits reading 0. rdata shows the value one clock after rd_en is sampled and shows 0 in cycles with no read. Unmapped or misaligned addresses read 0 and ignore writes.
- R3: Prescaler c ticks once every N clocks when N > 0 and the counting enable of channel c is set. A channel's duty counter steps on each tick of its selected prescaler and wraps from 255 to 0, so exactly one high window of D ticks occurs per 256 ticks.
- R4: With the output enabled, the force-high override clear and N > 0, the output is high for N × D clocks out of every N × 256 clocks.
- R5: With the output enable set and the force-high bit set, the output is constantly high.
- R6: With the output enable clear, the output is low, whatever the force-high bit is.
- R7: With the counting enable of a channel clear, its prescaler and duty counter are held at 0. Once the enable is set, the period starts from its beginning.
- R8: A prescaler value of 0 produces no ticks, so the duty counter stays where it is.
- R9: A new prescaler value applies at once. If the running count has reached or passed the new N − 1, a tick happens on the next clock.
- R10: Bits 9:8 of the duty register choose which prescaler steps the channel's duty counter.
- R11: A duty value of 0 with the force-high bit clear gives a constantly low output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after rd_en |
| pwm_out | output | 4 | PWM outputs, bit c for channel c |

## Verification
A register write takes effect on the clock edge that samples wr_en. Because the PWM outputs are decoded directly from registers, they can change in the half-cycle after that edge. Read data appears one edge after rd_en. The bench's reference model steps on the same rising edge as the design, using the register values from before the edge. It compares every output and rdata at the following falling edge. The directed checks count high cycles over windows of whole periods, so the result does not depend on where in a period the window starts. The immediate-update check samples two falling edges after the prescaler write, which is the first cycle in which the new tick has moved the duty counter.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  localparam int unsigned MODE_WORD  = 0;
  localparam int unsigned CNTEN_WORD = 1;
  localparam int unsigned FREQ_BASE  = 2;
  localparam int unsigned BYP_LSB    = 8;
  localparam int unsigned SEL_LSB    = 8;

  function automatic int unsigned duty_word(int unsigned nch, int unsigned ch);
    return FREQ_BASE + nch + ch;
  endfunction
endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned FREQ_W = 16,
  parameter int unsigned DUTY_W = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SEL_W  = $clog2(NCH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [31:0]                  wdata,
  output logic [31:0]                  rdata,
  output logic [NCH-1:0]               en_o,
  output logic [NCH-1:0]               byp_o,
  output logic [NCH-1:0]               cnten_o,
  output logic [NCH-1:0][FREQ_W-1:0]   freq_o,
  output logic [NCH-1:0][DUTY_W-1:0]   duty_o,
  output logic [NCH-1:0][SEL_W-1:0]    sel_o
);
  import pwm4_pkg::*;

  logic [NCH-1:0]             en_q, en_d, byp_q, byp_d, cnten_q, cnten_d;
  logic [NCH-1:0][FREQ_W-1:0] freq_q, freq_d;
  logic [NCH-1:0][DUTY_W-1:0] duty_q, duty_d;
  logic [NCH-1:0][SEL_W-1:0]  sel_q, sel_d;
  logic [31:0]                rd_val, rdata_d, rdata_q;
  logic                       aligned;
  int unsigned                word;
  logic                       unused_wdata;

  assign aligned      = (addr[1:0] == 2'b00);
  assign word         = 32'(addr[ADDR_W-1:2]);
  assign unused_wdata = &{1'b0, wdata[31:16]};

  always_comb begin
    en_d    = en_q;
    byp_d   = byp_q;
    cnten_d = cnten_q;
    freq_d  = freq_q;
    duty_d  = duty_q;
    sel_d   = sel_q;
    if (wr_en && aligned) begin
      if (word == MODE_WORD) begin
        en_d  = wdata[NCH-1:0];
        byp_d = wdata[BYP_LSB +: NCH];
      end
      if (word == CNTEN_WORD) cnten_d = wdata[NCH-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (word == FREQ_BASE + c) freq_d[c] = wdata[FREQ_W-1:0];
        if (word == duty_word(NCH, c)) begin
          duty_d[c] = wdata[DUTY_W-1:0];
          sel_d[c]  = wdata[SEL_LSB +: SEL_W];
        end
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (aligned) begin
      if (word == MODE_WORD) begin
        rd_val[NCH-1:0]       = en_q;
        rd_val[BYP_LSB +: NCH] = byp_q;
      end
      if (word == CNTEN_WORD) rd_val[NCH-1:0] = cnten_q;
      for (int c = 0; c < NCH; c++) begin
        if (word == FREQ_BASE + c) rd_val[FREQ_W-1:0] = freq_q[c];
        if (word == duty_word(NCH, c)) begin
          rd_val[DUTY_W-1:0]      = duty_q[c];
          rd_val[SEL_LSB +: SEL_W] = sel_q[c];
        end
      end
    end
    rdata_d = rd_en ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      byp_q   <= '0;
      cnten_q <= '0;
      freq_q  <= '0;
      duty_q  <= '0;
      sel_q   <= '0;
      rdata_q <= '0;
    end else begin
      en_q    <= en_d;
      byp_q   <= byp_d;
      cnten_q <= cnten_d;
      freq_q  <= freq_d;
      duty_q  <= duty_d;
      sel_q   <= sel_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata   = rdata_q;
  assign en_o    = en_q;
  assign byp_o   = byp_q;
  assign cnten_o = cnten_q;
  assign freq_o  = freq_q;
  assign duty_o  = duty_q;
  assign sel_o   = sel_q;

  assert_wr_freq0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && aligned && word == FREQ_BASE) |=> (freq_q[0] == $past(wdata[FREQ_W-1:0])));
  assert_wr_cnten_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && aligned && word == CNTEN_WORD) |=> (cnten_q == $past(wdata[NCH-1:0])));
endmodule

// File: rtl/pwm4_prescaler.sv
module pwm4_prescaler #(
  parameter int unsigned FREQ_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic              tick_o
);
  logic [FREQ_W-1:0] cnt_q, cnt_d;
  logic              run;

  assign run    = cnt_en_i && (freq_i != '0);
  assign tick_o = run && (cnt_q >= freq_i - 1'b1);

  always_comb begin
    if (!run || tick_o) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_tick_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));
  assert_gate_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en_i) |=> (cnt_q == '0));
  assert_zero_div_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_i == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/pwm4_channel.sv
module pwm4_channel #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned DUTY_W = 8,
  parameter int unsigned SEL_W  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    tick_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              cnt_en_i,
  input  logic              en_i,
  input  logic              byp_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  logic [DUTY_W-1:0] dc_q, dc_d;
  logic              step;

  assign step = tick_i[sel_i];

  always_comb begin
    if (!cnt_en_i) dc_d = '0;
    else if (step) dc_d = dc_q + 1'b1;
    else           dc_d = dc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dc_q <= '0;
    else        dc_q <= dc_d;
  end

  assign pwm_o = en_i && (byp_i || (dc_q < duty_i));

  assert_hold_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en_i) |=> (dc_q == '0));
  assert_no_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en_i && !step) |=> $stable(dc_q));
  assert_step_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en_i && step) |=> (dc_q == DUTY_W'($past(dc_q) + 1'b1)));
endmodule

// File: rtl/pwm4_ctrl.sv
module pwm4_ctrl #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned FREQ_W = 16,
  parameter int unsigned DUTY_W = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int unsigned SEL_W = $clog2(NCH);

  logic                       rst_s1, rst_s2;
  logic [NCH-1:0]             en, byp, cnten, tick;
  logic [NCH-1:0][FREQ_W-1:0] freq;
  logic [NCH-1:0][DUTY_W-1:0] duty;
  logic [NCH-1:0][SEL_W-1:0]  sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  pwm4_regs #(.NCH(NCH), .FREQ_W(FREQ_W), .DUTY_W(DUTY_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) regs_i (
    .clk(clk), .rst_n(rst_s2), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .en_o(en), .byp_o(byp), .cnten_o(cnten), .freq_o(freq), .duty_o(duty),
    .sel_o(sel)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm4_prescaler #(.FREQ_W(FREQ_W)) div_i (
      .clk(clk), .rst_n(rst_s2), .cnt_en_i(cnten[c]), .freq_i(freq[c]), .tick_o(tick[c])
    );
    pwm4_channel #(.NCH(NCH), .DUTY_W(DUTY_W), .SEL_W(SEL_W)) ch_i (
      .clk(clk), .rst_n(rst_s2), .tick_i(tick), .sel_i(sel[c]), .cnt_en_i(cnten[c]),
      .en_i(en[c]), .byp_i(byp[c]), .duty_i(duty[c]), .pwm_o(pwm_out[c])
    );
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    (!rst_s2) |-> (pwm_out == '0));
endmodule

// File: tb/pwm4_ctrl_tb_top.sv
module pwm4_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm_out;

  int checks = 0, fails = 0, cycles = 0;
  bit chk_on = 0, done = 0;

  int m_en[4], m_byp[4], m_cnten[4], m_freq[4], m_duty[4], m_sel[4];
  int m_div[4], m_dc[4], m_t[4];
  int m_rd = 0, m_rst = 0;

  always #5 clk = ~clk;

  pwm4_ctrl dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                   .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_read(int a);
    int v = 0;
    if (a % 4 != 0) return 0;
    for (int c = 0; c < 4; c++) begin
      if (a == 0) v = v | (m_en[c] << c) | (m_byp[c] << (8 + c));
      if (a == 4) v = v | (m_cnten[c] << c);
      if (a == 8 + 4 * c) v = m_freq[c];
      if (a == 24 + 4 * c) v = m_duty[c] | (m_sel[c] << 8);
    end
    return v;
  endfunction

  task automatic model_write(int a, int d);
    if (a % 4 != 0) return;
    for (int c = 0; c < 4; c++) begin
      if (a == 0) begin m_en[c] = (d >> c) & 1; m_byp[c] = (d >> (8 + c)) & 1; end
      if (a == 4) m_cnten[c] = (d >> c) & 1;
      if (a == 8 + 4 * c) m_freq[c] = d & 16'hFFFF;
      if (a == 24 + 4 * c) begin m_duty[c] = d & 8'hFF; m_sel[c] = (d >> 8) & 3; end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_en[c] = 0; m_byp[c] = 0; m_cnten[c] = 0; m_freq[c] = 0;
        m_duty[c] = 0; m_sel[c] = 0; m_div[c] = 0; m_dc[c] = 0;
      end
      m_rd = 0; m_rst = 0;
    end else if (m_rst < 2) begin
      m_rst++;
    end else begin
      for (int d = 0; d < 4; d++)
        m_t[d] = (m_cnten[d] != 0 && m_freq[d] != 0 && m_div[d] >= m_freq[d] - 1) ? 1 : 0;
      for (int d = 0; d < 4; d++) begin
        if (m_cnten[d] == 0 || m_freq[d] == 0 || m_t[d] != 0) m_div[d] = 0;
        else m_div[d] = m_div[d] + 1;
      end
      for (int c = 0; c < 4; c++) begin
        if (m_cnten[c] == 0) m_dc[c] = 0;
        else if (m_t[m_sel[c]] != 0) m_dc[c] = (m_dc[c] + 1) % 256;
      end
      m_rd = rd_en ? model_read(int'(addr)) : 0;
      if (wr_en) model_write(int'(addr), int'(wdata));
    end
  end

  function automatic string tag_of(int c);
    if (m_en[c] == 0) return "R6";
    if (m_byp[c] != 0) return "R5";
    if (m_duty[c] == 0) return "R11";
    if (m_cnten[c] == 0) return "R7";
    if (m_freq[m_sel[c]] == 0) return "R8";
    return "R4";
  endfunction

  always @(negedge clk) begin
    if (chk_on) begin
      for (int c = 0; c < 4; c++) begin
        int e;
        e = (m_en[c] != 0 && (m_byp[c] != 0 || m_dc[c] < m_duty[c])) ? 1 : 0;
        check(pwm_out[c] == e[0], $sformatf("%s model pwm_out[%0d]", tag_of(c), c),
              longint'(pwm_out[c]), longint'(e));
      end
      check(rdata == m_rd[31:0], "R2 model rdata", longint'(rdata), longint'(m_rd));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; addr = a[7:0]; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    rd_en = 1'b1; addr = a[7:0];
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rdata);
  endtask

  task automatic count_high(int c, int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[c]) h++;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000 && !done) begin
      done = 1;
      check(0, "watchdog", cycles, 60000);
      finish_run();
    end
  end

  initial begin
    int v, h;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_on = 1;
    check(pwm_out == 4'b0, "R1 outputs low in reset", longint'(pwm_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pwm_out == 4'b0, "R1 outputs low after reset", longint'(pwm_out), 0);
    check(rdata == 32'b0, "R1 rdata zero after reset", longint'(rdata), 0);
    for (int a = 0; a < 40; a += 4) begin
      rd(a, v);
      check(v == 0, $sformatf("R1 reg 0x%0h reset value", a), v, 0);
    end

    // R2: readback with undefined bits masked
    for (int a = 0; a < 44; a += 4) wr(a, 32'hFFFF_FFFF);
    rd(0, v);  check(v == 32'h0F0F, "R2 mode readback", v, 32'h0F0F);
    rd(4, v);  check(v == 32'h000F, "R2 count enable readback", v, 32'h000F);
    rd(12, v); check(v == 32'hFFFF, "R2 prescaler readback", v, 32'hFFFF);
    rd(36, v); check(v == 32'h03FF, "R2 duty readback", v, 32'h03FF);
    rd(40, v); check(v == 0, "R2 unmapped reads zero", v, 0);
    rd(9, v);  check(v == 0, "R2 misaligned reads zero", v, 0);
    for (int a = 0; a < 40; a += 4) wr(a, 0);
    wr(13, 32'h55);
    rd(12, v); check(v == 0, "R2 misaligned write ignored", v, 0);

    // R4: N=3, D=10 on channel 0
    wr(8, 3); wr(24, 10); wr(4, 1); wr(0, 1);
    count_high(0, 768, h); check(h == 30, "R4 high clocks per period", h, 30);
    count_high(0, 1536, h); check(h == 60, "R4 high clocks over two periods", h, 60);

    // R11: duty zero
    wr(24, 0);
    count_high(0, 768, h); check(h == 0, "R11 duty zero stays low", h, 0);

    // R5 / R6: force-high and output enable
    wr(0, 32'h101);
    count_high(0, 100, h); check(h == 100, "R5 force-high output", h, 100);
    wr(0, 32'h100);
    count_high(0, 100, h); check(h == 0, "R6 disabled overrides force-high", h, 0);
    wr(0, 1); wr(24, 10);

    // R8: channel 1 on prescaler 1 with N=0, D=128
    wr(28, (1 << 8) | 128); wr(4, 3); wr(0, 3);
    count_high(1, 1000, h); check(h == 1000, "R8 zero prescaler holds counter", h, 1000);

    // R7: channel 2, N=2, D=5, counting gated then released
    wr(16, 2); wr(32, (2 << 8) | 5); wr(0, 7);
    count_high(2, 300, h); check(h == 300, "R7 gated counter held at zero", h, 300);
    wr(4, 7);
    count_high(2, 512, h); check(h == 10, "R7 restart from period start", h, 10);

    // R10: channel 3 follows prescaler 0 (N=3) while its own is 0
    wr(36, (0 << 8) | 20); wr(4, 15); wr(0, 15);
    count_high(3, 768, h); check(h == 60, "R10 borrowed prescaler", h, 60);

    // R9: immediate prescaler change on channel 0
    wr(4, 14); wr(8, 1000); wr(24, 1); wr(4, 15);
    repeat (100) @(negedge clk);
    check(pwm_out[0] == 1'b1, "R9 long first tick still high", longint'(pwm_out[0]), 1);
    wr(8, 1);
    repeat (2) @(negedge clk);
    check(pwm_out[0] == 1'b0, "R9 new prescaler applied at once", longint'(pwm_out[0]), 0);

    // R3: N=1, D=1 gives one high clock per 256 clocks
    count_high(0, 512, h); check(h == 2, "R3 duty counter wraps every 256 ticks", h, 2);

    done = 1;
    finish_run();
  end
endmodule